// File: doc/BRIEF.md
# SMRAM Address Window Router

This block sits on the memory request path of a host bridge and decides, for every access, where the access is sent. There are three possible targets: system DRAM, the legacy video/PCI path, and a discard sink. Discarded writes are dropped, and discarded reads return all-ones from that sink.

The decision depends on four things:

- the access address;
- whether the requester is a CPU running in system management mode (SMM);
- whether the requester is a bus-master DMA agent;
- a set of control bits held elsewhere in the bridge.

Three protected ranges are handled:

- the 128 KB legacy window at 0xA0000–0xBFFFF;
- an upper alias of that window at 0xFEDA0000–0xFEDBFFFF, which is translated down onto the same DRAM;
- a protected segment (TSEG) placed directly below the top of low memory.

Each access is routed using the inputs present at a clock edge. The target select and the translated DRAM address are available from the register one cycle later. The control bits are plain inputs, so the closed state after reset is set by whoever drives them. With all control bits at zero the legacy window is closed.

Top module: `smram_router`

## Requirements
- R1: Outputs are registered: `route_tgt`/`route_addr` reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low they hold discard (3'b100) and address 0.
- R2: `route_tgt` is always one-hot with bit 0 = DRAM, bit 1 = legacy video/PCI path, bit 2 = discard.
- R3: For a non-SMM, non-DMA access in 0xA0000–0xBFFFF with the high enable at 0, the target is the legacy path when the open bit is 0 and DRAM when the open bit is 1.
- R4: For an SMM CPU access (SMM flag 1, DMA flag 0) in 0xA0000–0xBFFFF with the high enable at 0:
  - the target is DRAM when the global enable is 1;
  - with the global enable at 0, the target follows the open bit exactly as in R3.
- R5: With the high enable at 1:
  - every access to 0xA0000–0xBFFFF goes to the legacy path, SMM included;
  - an access to 0xFEDA0000–0xFEDBFFFF goes to DRAM when the requester may see SMRAM (open bit 1, or SMM CPU with global enable 1);
  - otherwise that access goes to the legacy path.
  - With the high enable at 0, the upper range always goes to the legacy path.
- R6: `route_addr` equals the access address minus 0xFED00000 inside 0xFEDA0000–0xFEDBFFFF, and equals the access address unchanged everywhere else.
- R7: TSEG is active only when its enable bit is 1 and its 2-bit size code is not 11. Sizes are 00 = 1 MB, 01 = 2 MB and 10 = 8 MB. TSEG covers [top − size, top − 1], where top is `top_low_mem`.
- R8: Inside an active TSEG:
  - an SMM CPU access goes to DRAM;
  - every non-SMM CPU access and every DMA access goes to discard.
- R9: A DMA access never reaches DRAM through the legacy or upper window, whatever the open, global or high bits say; it goes to the legacy path.
- R10: Outside the two windows and any active TSEG, an address below `top_low_mem` goes to DRAM and any other address goes to the legacy/PCI path. The windows take priority over TSEG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_smm | input | 1 | Requester is a CPU in system management mode |
| acc_dma | input | 1 | Requester is a bus-master DMA agent |
| ctl_open | input | 1 | Expose SMRAM to non-SMM CPU accesses |
| ctl_glob_en | input | 1 | Global SMRAM enable for the SMM view |
| ctl_high_en | input | 1 | Move SMRAM from the legacy window to the upper alias |
| ctl_tseg_en | input | 1 | TSEG enable |
| ctl_tseg_sz | input | 2 | TSEG size code (00 1 MB, 01 2 MB, 10 8 MB, 11 off) |
| top_low_mem | input | ADDR_W | Top of low memory; TSEG ends just below it |
| route_tgt | output | 3 | One-hot target: bit0 DRAM, bit1 legacy/PCI, bit2 discard |
| route_addr | output | ADDR_W | Translated DRAM address |

## Verification
Both results, the target select and the translated address, are due exactly one rising edge after the inputs that produce them. The bench changes all inputs on the falling edge. On the next falling edge it compares both outputs against a behavioural model evaluated on the inputs it applied half a period before that rising edge, so every comparison lands in the first cycle in which the result is valid. During reset the outputs are compared on falling edges against the reset values. The directed vectors straddle each window and TSEG edge by one byte, and these are followed by region-biased random accesses with changing control bits.

// File: rtl/smram_pkg.sv
package smram_pkg;

    // One-hot routing target
    typedef enum logic [2:0] {
        TGT_DRAM = 3'b001,
        TGT_LEG  = 3'b010,
        TGT_DROP = 3'b100
    } tgt_e;

    // Fixed address map of the protected windows
    localparam logic [31:0] LOW_FIRST  = 32'h000A_0000;
    localparam logic [31:0] LOW_LAST   = 32'h000B_FFFF;
    localparam logic [31:0] HIGH_FIRST = 32'hFEDA_0000;
    localparam logic [31:0] HIGH_LAST  = 32'hFEDB_FFFF;
    localparam logic [31:0] HIGH_SHIFT = 32'hFED0_0000;

    // log2 of the TSEG sizes for codes 00, 01, 10
    localparam int TSEG_LOG_SZ0 = 20;
    localparam int TSEG_LOG_SZ1 = 21;
    localparam int TSEG_LOG_SZ2 = 23;

endpackage

// File: rtl/smram_win_decode.sv
module smram_win_decode
    import smram_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_low,
    output logic              in_high,
    output logic [ADDR_W-1:0] xlat_addr
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LOW_FIRST);
    localparam logic [ADDR_W-1:0] LO_B = ADDR_W'(LOW_LAST);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HIGH_FIRST);
    localparam logic [ADDR_W-1:0] HI_B = ADDR_W'(HIGH_LAST);
    localparam logic [ADDR_W-1:0] HI_S = ADDR_W'(HIGH_SHIFT);

    always_comb begin
        in_low    = (addr >= LO_A) && (addr <= LO_B);
        in_high   = (addr >= HI_A) && (addr <= HI_B);
        xlat_addr = in_high ? (addr - HI_S) : addr;
    end
endmodule

// File: rtl/smram_tseg_decode.sv
module smram_tseg_decode
    import smram_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] top,
    input  logic              seg_en,
    input  logic [1:0]        seg_sz,
    output logic              hit
);
    logic [ADDR_W-1:0] seg_size;
    logic [ADDR_W-1:0] seg_base;
    logic              seg_on;

    always_comb begin
        unique case (seg_sz)
            2'b00:   seg_size = ADDR_W'(1) << TSEG_LOG_SZ0;
            2'b01:   seg_size = ADDR_W'(1) << TSEG_LOG_SZ1;
            2'b10:   seg_size = ADDR_W'(1) << TSEG_LOG_SZ2;
            default: seg_size = '0;
        endcase
        seg_on   = seg_en && (seg_sz != 2'b11);
        seg_base = top - seg_size;
        hit      = seg_on && (addr >= seg_base) && (addr < top);
    end
endmodule

// File: rtl/smram_router.sv
module smram_router
    import smram_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  logic              acc_dma,
    input  logic              ctl_open,
    input  logic              ctl_glob_en,
    input  logic              ctl_high_en,
    input  logic              ctl_tseg_en,
    input  logic [1:0]        ctl_tseg_sz,
    input  logic [ADDR_W-1:0] top_low_mem,
    output logic [2:0]        route_tgt,
    output logic [ADDR_W-1:0] route_addr
);
    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] addr;
    } route_t;

    route_t route_d, route_q;

    logic              in_low, in_high, tseg_hit;
    logic [ADDR_W-1:0] xlat_addr;
    logic              smm_cpu, may_see;

    smram_win_decode #(.ADDR_W(ADDR_W)) i_win (
        .addr      (acc_addr),
        .in_low    (in_low),
        .in_high   (in_high),
        .xlat_addr (xlat_addr)
    );

    smram_tseg_decode #(.ADDR_W(ADDR_W)) i_tseg (
        .addr   (acc_addr),
        .top    (top_low_mem),
        .seg_en (ctl_tseg_en),
        .seg_sz (ctl_tseg_sz),
        .hit    (tseg_hit)
    );

    always_comb begin
        smm_cpu = acc_smm && !acc_dma;
        may_see = !acc_dma && (ctl_open || (smm_cpu && ctl_glob_en));

        route_d.addr = xlat_addr;
        if (in_low) begin
            route_d.tgt = (!ctl_high_en && may_see) ? TGT_DRAM : TGT_LEG;
        end else if (in_high) begin
            route_d.tgt = (ctl_high_en && may_see) ? TGT_DRAM : TGT_LEG;
        end else if (tseg_hit) begin
            route_d.tgt = smm_cpu ? TGT_DRAM : TGT_DROP;
        end else if (acc_addr < top_low_mem) begin
            route_d.tgt = TGT_DRAM;
        end else begin
            route_d.tgt = TGT_LEG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= '{tgt: TGT_DROP, addr: '0};
        end else begin
            route_q <= route_d;
        end
    end

    assign route_tgt  = route_q.tgt;
    assign route_addr = route_q.addr;
endmodule

// File: rtl/smram_router_chk.sv
module smram_router_chk
    import smram_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_smm,
    input logic              acc_dma,
    input logic              ctl_open,
    input logic              ctl_glob_en,
    input logic              ctl_high_en,
    input logic              ctl_tseg_en,
    input logic [1:0]        ctl_tseg_sz,
    input logic [ADDR_W-1:0] top_low_mem,
    input logic [2:0]        route_tgt,
    input logic [ADDR_W-1:0] route_addr
);
    localparam logic [ADDR_W-1:0] ONE_MB = ADDR_W'(1) << 20;

    logic low_rng, high_rng, inner_seg;
    always_comb begin
        low_rng   = (acc_addr >= ADDR_W'(LOW_FIRST)) && (acc_addr <= ADDR_W'(LOW_LAST));
        high_rng  = (acc_addr >= ADDR_W'(HIGH_FIRST)) && (acc_addr <= ADDR_W'(HIGH_LAST));
        inner_seg = (acc_addr >= top_low_mem - ONE_MB) && (acc_addr < top_low_mem)
                    && !low_rng && !high_rng;
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(route_tgt) == 1);

    p_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (low_rng && !ctl_open && !acc_smm) |=> (route_tgt == 3'b010));

    p_xlat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        high_rng |=> (route_addr == $past(acc_addr) - ADDR_W'(HIGH_SHIFT)));

    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !high_rng |=> (route_addr == $past(acc_addr)));

    p_tseg_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_tseg_en && (ctl_tseg_sz != 2'b11) && inner_seg && !(acc_smm && !acc_dma))
        |=> (route_tgt == 3'b100));

    p_dma_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_dma && (low_rng || high_rng)) |=> (route_tgt == 3'b010));
endmodule

bind smram_router smram_router_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_addr    (acc_addr),
    .acc_smm     (acc_smm),
    .acc_dma     (acc_dma),
    .ctl_open    (ctl_open),
    .ctl_glob_en (ctl_glob_en),
    .ctl_high_en (ctl_high_en),
    .ctl_tseg_en (ctl_tseg_en),
    .ctl_tseg_sz (ctl_tseg_sz),
    .top_low_mem (top_low_mem),
    .route_tgt   (route_tgt),
    .route_addr  (route_addr)
);

// File: tb/test_smram_router.sv
`timescale 1ns/1ps
module test_smram_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_smm = 1'b0, acc_dma = 1'b0;
    logic        ctl_open = 1'b0, ctl_glob_en = 1'b0, ctl_high_en = 1'b0, ctl_tseg_en = 1'b0;
    logic [1:0]  ctl_tseg_sz = 2'b00;
    logic [31:0] top_low_mem = 32'h8000_0000;
    logic [2:0]  route_tgt;
    logic [31:0] route_addr;

    int compared = 0;
    int mismatched = 0;

    logic        have_exp = 1'b0;
    logic [2:0]  exp_tgt;
    logic [31:0] exp_addr;
    string       exp_tag;

    always #2.5 clk = ~clk;

    smram_router #(.ADDR_W(32)) i_smram_router (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_dma(acc_dma),
        .ctl_open(ctl_open), .ctl_glob_en(ctl_glob_en), .ctl_high_en(ctl_high_en),
        .ctl_tseg_en(ctl_tseg_en), .ctl_tseg_sz(ctl_tseg_sz), .top_low_mem(top_low_mem),
        .route_tgt(route_tgt), .route_addr(route_addr)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural routing model built from the requirements
    task automatic model(output logic [2:0] t, output logic [31:0] ea, output string tag);
        longint a   = longint'(acc_addr);
        longint top = longint'(top_low_mem);
        longint sz;
        bit     cpu_smm = acc_smm && !acc_dma;
        bit     see     = !acc_dma && (ctl_open || (cpu_smm && ctl_glob_en));
        bit     in_hi   = (a >= 64'hFEDA0000) && (a <= 64'hFEDB_FFFF);
        ea = in_hi ? acc_addr - 32'hFED0_0000 : acc_addr;
        if (a >= 64'hA0000 && a <= 64'hBFFFF) begin
            if (acc_dma)          tag = "R9";
            else if (ctl_high_en) tag = "R5";
            else if (acc_smm)     tag = "R4";
            else                  tag = "R3";
            t = (see && !ctl_high_en) ? 3'b001 : 3'b010;
        end else if (in_hi) begin
            tag = acc_dma ? "R9" : "R5";
            t = (see && ctl_high_en) ? 3'b001 : 3'b010;
        end else begin
            case (ctl_tseg_sz)
                2'b00:   sz = 64'd1 << 20;
                2'b01:   sz = 64'd2 << 20;
                default: sz = 64'd8 << 20;
            endcase
            if (ctl_tseg_en && ctl_tseg_sz != 2'b11 && a >= top - sz && a < top) begin
                tag = "R7 R8";
                t = cpu_smm ? 3'b001 : 3'b100;
            end else begin
                tag = "R10";
                t = (a < top) ? 3'b001 : 3'b010;
            end
        end
    endtask

    // One cycle: check the result of the previous stimulus, then apply a new one
    task automatic step(input logic [31:0] a, input logic smm, input logic dma,
                        input logic op, input logic gl, input logic hi,
                        input logic ten, input logic [1:0] tsz, input logic [31:0] top);
        @(negedge clk);
        if (have_exp) begin
            check({"R1 ", exp_tag}, route_tgt, exp_tgt);
            check("R6", route_addr, exp_addr);
            check("R2", $countones(route_tgt), 1);
        end
        acc_addr = a; acc_smm = smm; acc_dma = dma;
        ctl_open = op; ctl_glob_en = gl; ctl_high_en = hi;
        ctl_tseg_en = ten; ctl_tseg_sz = tsz; top_low_mem = top;
        model(exp_tgt, exp_addr, exp_tag);
        have_exp = 1'b1;
    endtask

    task automatic random_addr(input logic [31:0] top, output logic [31:0] a);
        case ($urandom % 6)
            0: a = 32'h0009_0000 + ($urandom % 32'h4_0000);
            1: a = 32'hFED9_0000 + ($urandom % 32'h4_0000);
            2: a = top - 32'h0090_0000 + ($urandom % 32'h00A0_0000);
            3: a = $urandom % top;
            4: a = top + ($urandom % 32'h1000_0000);
            default: a = $urandom;
        endcase
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            check("R1 reset tgt", route_tgt, 3'b100);
            check("R1 reset addr", route_addr, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3 closed / open, non-SMM
        step(32'h000A_0000, 0, 0, 0, 0, 0, 0, 2'b00, 32'h8000_0000);
        step(32'h000B_FFFF, 0, 0, 1, 0, 0, 0, 2'b00, 32'h8000_0000);
        step(32'h0009_FFFF, 0, 0, 0, 0, 0, 0, 2'b00, 32'h8000_0000);
        step(32'h000C_0000, 0, 0, 0, 0, 0, 0, 2'b00, 32'h8000_0000);
        // R4 SMM with and without global enable
        step(32'h000A_8000, 1, 0, 0, 1, 0, 0, 2'b00, 32'h8000_0000);
        step(32'h000A_8000, 1, 0, 0, 0, 0, 0, 2'b00, 32'h8000_0000);
        step(32'h000A_8000, 1, 0, 1, 0, 0, 0, 2'b00, 32'h8000_0000);
        // R5 high enable, R6 translation
        step(32'h000A_8000, 1, 0, 1, 1, 1, 0, 2'b00, 32'h8000_0000);
        step(32'hFEDA_0000, 1, 0, 0, 1, 1, 0, 2'b00, 32'h8000_0000);
        step(32'hFEDB_FFFF, 0, 0, 1, 0, 1, 0, 2'b00, 32'h8000_0000);
        step(32'hFEDB_FFFF, 0, 0, 0, 0, 1, 0, 2'b00, 32'h8000_0000);
        step(32'hFEDA_0000, 1, 0, 1, 1, 0, 0, 2'b00, 32'h8000_0000);
        step(32'hFED9_FFFF, 1, 0, 1, 1, 1, 0, 2'b00, 32'h8000_0000);
        step(32'hFEDC_0000, 1, 0, 1, 1, 1, 0, 2'b00, 32'h8000_0000);
        // R9 DMA never sees SMRAM
        step(32'h000A_0000, 1, 1, 1, 1, 0, 0, 2'b00, 32'h8000_0000);
        step(32'hFEDA_1000, 0, 1, 1, 1, 1, 0, 2'b00, 32'h8000_0000);
        // R7 R8 TSEG edges for each size
        for (int s = 0; s < 4; s++) begin
            logic [31:0] b;
            b = 32'h8000_0000 - ((s == 0) ? 32'h10_0000 : (s == 1) ? 32'h20_0000 : 32'h80_0000);
            step(b - 1,          0, 0, 0, 0, 0, 1, 2'(s), 32'h8000_0000);
            step(b,              0, 0, 0, 0, 0, 1, 2'(s), 32'h8000_0000);
            step(b,              1, 0, 0, 0, 0, 1, 2'(s), 32'h8000_0000);
            step(32'h7FFF_FFFF,  1, 1, 0, 0, 0, 1, 2'(s), 32'h8000_0000);
            step(32'h7FFF_FFFF,  0, 0, 0, 0, 0, 0, 2'(s), 32'h8000_0000);
        end
        // R10 top of low memory edge
        step(32'h8000_0000, 0, 0, 0, 0, 0, 1, 2'b00, 32'h8000_0000);
        step(32'h3FFF_FFFF, 0, 0, 0, 0, 0, 0, 2'b00, 32'h4000_0000);

        // Region-biased random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] top, a;
            logic [3:0]  c;
            case ($urandom % 3)
                0: top = 32'h8000_0000;
                1: top = 32'hC000_0000;
                default: top = 32'h4000_0000;
            endcase
            random_addr(top, a);
            c = 4'($urandom);
            step(a, 1'($urandom), ($urandom % 4) == 0, c[0], c[1], c[2], c[3],
                 2'($urandom), top);
        end
        step(32'h0, 0, 0, 0, 0, 0, 0, 2'b00, 32'h8000_0000);
        @(negedge clk);
        check({"R1 ", exp_tag}, route_tgt, exp_tgt);
        check("R6", route_addr, exp_addr);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule